// File: doc/BRIEF.md
# Slot-Position Symbol Link

This block moves 4-bit symbols across one wire by pulse-position modulation. Each master period (nominally 50 ns at 20 MHz) is cut into sixteen equal slots of 3.125 ns, and a symbol is carried by the slot in which the line goes high. Symbol 0 rises at the start of the period. Each step of the code delays the edge by one more slot, so symbol 15 rises 46.875 ns into the period. Sixteen positions carry four bits per period, which gives 80 Mbit/s.

Transmitter and receiver both run on a fast clock at sixteen times the master rate. They share one free-running slot counter, and that counter defines the period boundaries. The transmitter takes at most one symbol per period through a valid/ready handshake. For a symbol s, the line is low in slots 0 to s-1 and high from slot s to the end of the period. The receiver samples the line every fast cycle. It reports the first slot in a period in which the line is high, and it flags an error for a period in which the line never goes high.

The receiver counts the level just before each period as low. A line that is already high in slot 0 therefore decodes as symbol 0, and a symbol 15 followed by a symbol 0 still decodes as two symbols. In normal use `line_out` is wired back to `line_in` through the channel. For test, any waveform can be applied to `line_in`.

Top module: `ppm_link`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `line_out`, `sym_ready`, `out_valid` and `out_err` are all low. After release the slot counter starts at slot 0.
- R2: `sym_ready` is high only in slot 15 of each period. A symbol is taken on the clock edge at which `sym_valid` and `sym_ready` are both high, and it is sent in the period that follows. The producer must hold `sym_valid` and `sym_data` until that edge.
- R3: For an accepted symbol s (0 to 15), `line_out` is low in slots 0 to s-1 and high in slots s to 15 of the transmit period.
- R4: In a period for which no symbol was accepted, `line_out` stays low in all sixteen slots.
- R5: After each period in which `line_in` is high in at least one slot, `out_valid` is high for exactly one cycle. That cycle is slot 0 of the next period.
- R6: After a period in which `line_in` is low in every slot, `out_err` is high for one cycle in slot 0 of the next period, and `out_valid` stays low.
- R7: `out_data` is the index of the first slot in the period in which `line_in` is high. Later pulses or levels in the same period do not change it.
- R8: With `line_out` looped to `line_in`, every accepted symbol is decoded to its own value, including a 15 followed directly by a 0.
- R9: `sym_data` has no effect on `line_out` unless a handshake takes place. This covers changes while `sym_valid` is low and changes while valid is high but ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast slot clock, sixteen times the master rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| sym_valid | input | 1 | Producer offers a symbol |
| sym_ready | output | 1 | High in the last slot of a period, when a symbol can be taken |
| sym_data | input | 4 | Symbol to send |
| line_out | output | 1 | Transmit wire |
| line_in | input | 1 | Receive wire |
| out_valid | output | 1 | One-cycle pulse with a decoded symbol |
| out_data | output | 4 | Decoded symbol (slot of first high sample) |
| out_err | output | 1 | One-cycle pulse for a period with no high sample |

## Verification
In loopback, all sixteen codes are sent back to back. This separates an off-by-one slot mapping from a correct one, and the 15-then-0 and 0-then-15 pairs test how the receiver handles the period boundary. Idle periods and a period with a held-off producer whose data keeps changing show whether the line stays quiet without a handshake. Line patterns are then injected directly on `line_in`: all low, all high, a single late slot, a one-slot glitch followed by a long pulse, and a pulse with a later second pulse. These separate first-edge capture from last-edge capture, and they separate error reporting from decoding a stale value.

// File: rtl/ppm_pkg.sv
package ppm_pkg;
  // Bits per symbol; the period holds 2**SYM_W slots.
  localparam int unsigned SYM_W_DEFAULT = 4;
endpackage

// File: rtl/ppm_phase_ctr.sv
module ppm_phase_ctr #(
  parameter int unsigned SYM_W = ppm_pkg::SYM_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [SYM_W-1:0] phase,
  output logic             last
);
  logic [SYM_W-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + SYM_W'(1);
  end

  assign phase = phase_q;
  assign last  = &phase_q;
endmodule

// File: rtl/ppm_tx.sv
module ppm_tx #(
  parameter int unsigned SYM_W = ppm_pkg::SYM_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] phase,
  input  logic             last,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [SYM_W-1:0] sym_data,
  output logic             line_out
);
  logic             hold_vld;
  logic [SYM_W-1:0] hold_sym;
  logic             line_q;
  logic [SYM_W-1:0] phase_nxt;

  assign sym_ready = last;
  assign phase_nxt = phase + SYM_W'(1);

  // line_q holds the level for the slot the counter is in.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_vld <= 1'b0;
      hold_sym <= '0;
      line_q   <= 1'b0;
    end else if (last) begin
      hold_vld <= sym_valid;
      hold_sym <= sym_data;
      line_q   <= sym_valid && (sym_data == '0);
    end else begin
      line_q   <= hold_vld && (phase_nxt >= hold_sym);
    end
  end

  assign line_out = line_q;

  // Once risen, the line stays high up to the end of the period.
  assert_line_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (line_q && !last) |=> line_q);

  // With nothing accepted, the line never rises.
  assert_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_vld |-> !line_q);

  // A handshake always lands at the start of a new period.
  assert_accept_boundary_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_valid && sym_ready) |=> (phase == '0));
endmodule

// File: rtl/ppm_rx.sv
module ppm_rx #(
  parameter int unsigned SYM_W = ppm_pkg::SYM_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYM_W-1:0] phase,
  input  logic             last,
  input  logic             line_in,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_data,
  output logic             out_err
);
  logic             found_q;
  logic [SYM_W-1:0] first_q;
  logic             seen;
  logic             hit;

  // found_q left over from the previous period is ignored in slot 0.
  assign seen = (phase != '0) && found_q;
  assign hit  = seen || line_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q   <= 1'b0;
      first_q   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_err   <= 1'b0;
    end else begin
      if (phase == '0) begin
        found_q <= line_in;
        first_q <= '0;
      end else if (!found_q && line_in) begin
        found_q <= 1'b1;
        first_q <= phase;
      end
      if (last) begin
        out_valid <= hit;
        out_err   <= !hit;
        out_data  <= seen ? first_q : phase;
      end else begin
        out_valid <= 1'b0;
        out_err   <= 1'b0;
      end
    end
  end

  // Results appear only in the first slot of a period.
  assert_result_slot0_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_err) |-> (phase == '0));

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  assert_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_valid, out_err}));
endmodule

// File: rtl/ppm_link.sv
module ppm_link #(
  parameter int unsigned SYM_W = ppm_pkg::SYM_W_DEFAULT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_valid,
  output logic             sym_ready,
  input  logic [SYM_W-1:0] sym_data,
  output logic             line_out,
  input  logic             line_in,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_data,
  output logic             out_err
);
  logic [SYM_W-1:0] phase;
  logic             last;

  ppm_phase_ctr #(.SYM_W(SYM_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .phase(phase), .last(last)
  );

  ppm_tx #(.SYM_W(SYM_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .phase(phase), .last(last),
    .sym_valid(sym_valid), .sym_ready(sym_ready), .sym_data(sym_data),
    .line_out(line_out)
  );

  ppm_rx #(.SYM_W(SYM_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .phase(phase), .last(last),
    .line_in(line_in), .out_valid(out_valid), .out_data(out_data),
    .out_err(out_err)
  );
endmodule

// File: tb/ppm_link_bench.sv
module ppm_link_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sym_valid = 1'b0;
  logic       sym_ready;
  logic [3:0] sym_data = 4'd0;
  logic       line_out;
  logic       line_in;
  logic       out_valid;
  logic [3:0] out_data;
  logic       out_err;
  logic       inj_mode = 1'b0;
  logic       inj_line = 1'b0;
  bit         noisy = 1'b0;

  int total = 0;
  int fails = 0;

  // Reference model state
  int ph = 0;
  bit m_vld = 0;
  int m_sym = 0;
  bit e_ov = 0;
  bit e_err = 0;
  int e_od = 0;
  bit ln_cycle = 0;
  bit samp[$];

  always #5 clk = ~clk;

  assign line_in = inj_mode ? inj_line : line_out;

  ppm_link u_ppm_link (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_ready(sym_ready),
    .sym_data(sym_data), .line_out(line_out), .line_in(line_in),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Behavioural model, advanced on every rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m_vld = 0; m_sym = 0; e_ov = 0; e_err = 0; e_od = 0;
      samp.delete();
    end else begin
      samp.push_back(ln_cycle);
      if (ph == 15) begin : period_end
        int first;
        first = -1;
        foreach (samp[i]) if (first < 0 && samp[i]) first = i;
        e_ov  = (first >= 0);
        e_err = (first < 0);
        if (first >= 0) e_od = first;
        samp.delete();
        m_vld = sym_valid;
        m_sym = int'(sym_data);
      end else begin
        e_ov = 0;
        e_err = 0;
      end
      ph = (ph + 1) % 16;
    end
  end

  // Compare on every cycle, away from the rising edge
  always @(negedge clk) begin
    #2;
    chk(noisy ? "R9" : (m_vld ? "R3" : "R4"), 32'(line_out), 32'(m_vld && ph >= m_sym));
    chk("R2", 32'(sym_ready), 32'(ph == 15));
    chk("R5", 32'(out_valid), 32'(e_ov));
    chk("R6", 32'(out_err), 32'(e_err));
    if (e_ov) chk(inj_mode ? "R7" : "R8", 32'(out_data), 32'(e_od));
    ln_cycle = line_in;
  end

  task automatic send(input int s);
    sym_valid = 1'b1;
    sym_data  = 4'(s);
    while (!sym_ready) @(negedge clk);
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  task automatic send_noisy(input int s);
    int k;
    k = 0;
    sym_valid = 1'b1;
    while (!sym_ready) begin
      sym_data = 4'(k * 7 + 3);
      k++;
      @(negedge clk);
    end
    sym_data = 4'(s);
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  task automatic inject(input logic [15:0] mask);
    while (ph != 0) @(negedge clk);
    inj_mode = 1'b1;
    repeat (16) begin
      inj_line = mask[ph];
      @(negedge clk);
    end
    inj_line = 1'b0;
  endtask

  task automatic idle_periods(input int n);
    repeat (16 * n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk("R1", 32'(line_out), 0);
    chk("R1", 32'(sym_ready), 0);
    chk("R1", 32'(out_valid), 0);
    chk("R1", 32'(out_err), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk("R1", 32'(sym_ready), 0);
    chk("R1", 32'(line_out), 0);
    @(negedge clk);

    // R8: every code in loopback, then boundary pairs
    for (int s = 0; s < 16; s++) send(s);
    send(15); send(0); send(0); send(15); send(7);
    idle_periods(2);   // R4 and R6: silent line

    // R9: data churn with valid low, then held off with valid high
    noisy = 1'b1;
    repeat (20) begin
      sym_data = sym_data + 4'd5;
      @(negedge clk);
    end
    noisy = 1'b0;
    send_noisy(9);
    idle_periods(2);

    // R7: injected line patterns
    inject(16'h0000);
    inject(16'hFFFF);
    inject(16'h8000);
    inject(16'h1E20);
    inject(16'h0408);
    inject(16'hFC00);
    @(negedge clk);
    inj_mode = 1'b0;
    idle_periods(2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule